// File: doc/BRIEF.md
# Read-Modify-Write Byte Operation Unit

This unit carries out one single-operand operation on a byte held in memory or in a register. A caller supplies a resolved address, an operation code and, for the bit operations, a 3-bit bit index, then pulses `start`. The unit reads the byte, computes the new value, and writes it back to the same address. It then raises `done` for one cycle.

All fourteen operations share one sequence of five states: idle, read, modify, write and done. The test operation walks the same path without the write state, so it only refreshes the flags. The unit keeps its own negative, zero and carry flags. The rotate operations feed the stored carry back into the byte.

The memory port is synchronous. Read data returns on the cycle after `mem_rd`, and a write commits at the clock edge that ends the `mem_wr` cycle.

Top module: `rmw_unit`

## Requirements
- R1: When `start` is high in the idle state, the unit asserts `mem_rd` on the next cycle. `done` follows exactly three cycles after `mem_rd` for writing operations and two cycles after it for the test operation, and it stays high for exactly one cycle.
- R2: `mem_rd` is high for exactly one cycle per operation. Every writing operation asserts `mem_wr` for exactly one cycle, two cycles after `mem_rd`, on the same address with the computed result.
- R3: Op code 13 (test) never asserts `mem_wr`. It sets N and Z from the value read and leaves C unchanged. Op codes 14 and 15 behave as test.
- R4: Op codes 0 and 8 are the same left shift, with 0 entering bit 0. Op code 1 shifts right and keeps bit 7. Op code 9 shifts right with 0 entering bit 7. For all four shifts, C takes the bit shifted out.
- R5: Op code 11 rotates left and op code 12 rotates right, both through carry: the old C enters the vacated end and the bit shifted out becomes the new C.
- R6: Op code 5 writes the one's complement and sets C to 1. Op code 10 writes the two's complement and sets C to 1 exactly when the result is non-zero.
- R7: Op code 7 increments and op code 6 decrements, both modulo 256, and both leave C unchanged.
- R8: Op code 4 writes 0x00 and sets Z=1, N=0 and C=0.
- R9: Op code 3 sets and op code 2 clears only the bit selected by `bit_idx`, leaving the other seven bits unchanged. These two operations leave all three flags unchanged.
- R10: For every operation except codes 2 and 3, N equals bit 7 of the result and Z is 1 exactly when the result is 0x00.
- R11: A `start` pulse that arrives while an operation is in progress is ignored: it causes no extra read, write or `done`.
- R12: After reset, `done`, `mem_rd`, `mem_wr` and all three flags are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start | input | 1 | Begin an operation (sampled in idle) |
| op | input | 4 | Operation code |
| bit_idx | input | 3 | Bit selected by the bit set/clear operations |
| addr | input | ADDR_W | Resolved operand address |
| done | output | 1 | One-cycle completion pulse |
| mem_addr | output | ADDR_W | Memory address |
| mem_rd | output | 1 | Memory read strobe |
| mem_wr | output | 1 | Memory write strobe |
| mem_wdata | output | 8 | Write data |
| mem_rdata | input | 8 | Read data, valid the cycle after `mem_rd` |
| flag_n | output | 1 | Negative flag |
| flag_z | output | 1 | Zero flag |
| flag_c | output | 1 | Carry flag |

## Verification
The hardest case to reach from the ports is a second `start` that arrives in the middle of a running sequence with a different address and operation. The bench fires one during the modify cycle of an increment and then watches the untouched address and the `done` line for any stray activity. Carry-chained behaviour is also awkward, because a rotate result depends on a carry left over from an earlier operation. The bench therefore runs operations back to back and carries its own flag model forward between them.

// File: rtl/rmw_pkg.sv
package rmw_pkg;
  localparam int DATA_W = 8;
  localparam int IDX_W  = $clog2(DATA_W);

  localparam logic [3:0] OP_ASL  = 4'd0;
  localparam logic [3:0] OP_ASR  = 4'd1;
  localparam logic [3:0] OP_BCLR = 4'd2;
  localparam logic [3:0] OP_BSET = 4'd3;
  localparam logic [3:0] OP_CLR  = 4'd4;
  localparam logic [3:0] OP_COM  = 4'd5;
  localparam logic [3:0] OP_DEC  = 4'd6;
  localparam logic [3:0] OP_INC  = 4'd7;
  localparam logic [3:0] OP_LSL  = 4'd8;
  localparam logic [3:0] OP_LSR  = 4'd9;
  localparam logic [3:0] OP_NEG  = 4'd10;
  localparam logic [3:0] OP_ROL  = 4'd11;
  localparam logic [3:0] OP_ROR  = 4'd12;
  localparam logic [3:0] OP_TST  = 4'd13;

  typedef enum logic [2:0] {
    ST_IDLE, ST_READ, ST_MODIFY, ST_WRITE, ST_DONE
  } rmw_state_e;

  typedef struct packed {
    logic [DATA_W-1:0] res;
    logic              c;
  } alu_out_t;

  function automatic logic op_is_test(input logic [3:0] op);
    return op >= OP_TST;
  endfunction

  function automatic logic op_is_bit(input logic [3:0] op);
    return (op == OP_BCLR) || (op == OP_BSET);
  endfunction

  function automatic alu_out_t rmw_compute(input logic [3:0] op,
                                           input logic [DATA_W-1:0] v,
                                           input logic cin,
                                           input logic [IDX_W-1:0] idx);
    alu_out_t o;
    logic [DATA_W-1:0] mask;
    mask = '0;
    mask[idx] = 1'b1;
    o.res = v;
    o.c   = cin;
    case (op)
      OP_ASL, OP_LSL: begin o.res = {v[DATA_W-2:0], 1'b0};         o.c = v[DATA_W-1]; end
      OP_ASR:         begin o.res = {v[DATA_W-1], v[DATA_W-1:1]};  o.c = v[0];        end
      OP_LSR:         begin o.res = {1'b0, v[DATA_W-1:1]};         o.c = v[0];        end
      OP_ROL:         begin o.res = {v[DATA_W-2:0], cin};          o.c = v[DATA_W-1]; end
      OP_ROR:         begin o.res = {cin, v[DATA_W-1:1]};          o.c = v[0];        end
      OP_BCLR:        o.res = v & ~mask;
      OP_BSET:        o.res = v | mask;
      OP_CLR:         begin o.res = '0;  o.c = 1'b0; end
      OP_COM:         begin o.res = ~v;  o.c = 1'b1; end
      OP_NEG:         begin o.res = ~v + 1'b1; o.c = |v; end
      OP_INC:         o.res = v + 1'b1;
      OP_DEC:         o.res = v - 1'b1;
      default:        o.res = v;
    endcase
    return o;
  endfunction
endpackage

// File: rtl/rmw_alu.sv
module rmw_alu
  import rmw_pkg::*;
(
  input  logic [3:0]        op,
  input  logic [DATA_W-1:0] opnd,
  input  logic              cin,
  input  logic [IDX_W-1:0]  idx,
  output logic [DATA_W-1:0] res,
  output logic              c_out,
  output logic              n_out,
  output logic              z_out,
  output logic              keep_flags
);
  alu_out_t r;
  always_comb begin
    r          = rmw_compute(op, opnd, cin, idx);
    res        = r.res;
    c_out      = r.c;
    n_out      = r.res[DATA_W-1];
    z_out      = (r.res == '0);
    keep_flags = op_is_bit(op);
  end
endmodule

// File: rtl/rmw_ctrl.sv
module rmw_ctrl
  import rmw_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic start,
  input  logic skip_wr,
  output logic accept,
  output logic rd_en,
  output logic cap_en,
  output logic wr_en,
  output logic done
);
  rmw_state_e state_q, state_d;

  always_comb begin
    state_d = state_q;
    case (state_q)
      ST_IDLE:   if (start) state_d = ST_READ;
      ST_READ:   state_d = ST_MODIFY;
      ST_MODIFY: state_d = skip_wr ? ST_DONE : ST_WRITE;
      ST_WRITE:  state_d = ST_DONE;
      default:   state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) state_q <= ST_IDLE;
    else        state_q <= state_d;
  end

  assign accept = (state_q == ST_IDLE) && start;
  assign rd_en  = (state_q == ST_READ);
  assign cap_en = (state_q == ST_MODIFY);
  assign wr_en  = (state_q == ST_WRITE);
  assign done   = (state_q == ST_DONE);

  // R11: a read only ever follows the idle state
  assert_read_from_idle_R11: assert property (@(posedge clk) disable iff (!rst_n)
    rd_en |-> $past(state_q == ST_IDLE));
endmodule

// File: rtl/rmw_flags.sv
module rmw_flags (
  input  logic clk,
  input  logic rst_n,
  input  logic upd,
  input  logic n_in,
  input  logic z_in,
  input  logic c_in,
  output logic n_q,
  output logic z_q,
  output logic c_q
);
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      n_q <= 1'b0;
      z_q <= 1'b0;
      c_q <= 1'b0;
    end else if (upd) begin
      n_q <= n_in;
      z_q <= z_in;
      c_q <= c_in;
    end
  end
endmodule

// File: rtl/rmw_unit.sv
module rmw_unit
  import rmw_pkg::*;
#(
  parameter int ADDR_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start,
  input  logic [3:0]        op,
  input  logic [IDX_W-1:0]  bit_idx,
  input  logic [ADDR_W-1:0] addr,
  output logic              done,
  output logic [ADDR_W-1:0] mem_addr,
  output logic              mem_rd,
  output logic              mem_wr,
  output logic [DATA_W-1:0] mem_wdata,
  input  logic [DATA_W-1:0] mem_rdata,
  output logic              flag_n,
  output logic              flag_z,
  output logic              flag_c
);
  logic [3:0]        op_q;
  logic [IDX_W-1:0]  idx_q;
  logic [ADDR_W-1:0] addr_q;
  logic [DATA_W-1:0] res_q, opnd_q;

  // named internal events
  logic accept, rd_en, cap_en, wr_en;
  logic [DATA_W-1:0] alu_res;
  logic alu_c, alu_n, alu_z, alu_keep;
  logic flag_upd;

  rmw_ctrl u_ctrl (
    .clk(clk), .rst_n(rst_n), .start(start), .skip_wr(op_is_test(op_q)),
    .accept(accept), .rd_en(rd_en), .cap_en(cap_en), .wr_en(wr_en), .done(done)
  );

  rmw_alu u_alu (
    .op(op_q), .opnd(mem_rdata), .cin(flag_c), .idx(idx_q),
    .res(alu_res), .c_out(alu_c), .n_out(alu_n), .z_out(alu_z), .keep_flags(alu_keep)
  );

  assign flag_upd = cap_en && !alu_keep;

  rmw_flags u_flags (
    .clk(clk), .rst_n(rst_n), .upd(flag_upd),
    .n_in(alu_n), .z_in(alu_z), .c_in(alu_c),
    .n_q(flag_n), .z_q(flag_z), .c_q(flag_c)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      op_q   <= OP_TST;
      idx_q  <= '0;
      addr_q <= '0;
      res_q  <= '0;
      opnd_q <= '0;
    end else begin
      if (accept) begin
        op_q   <= op;
        idx_q  <= bit_idx;
        addr_q <= addr;
      end
      if (cap_en) begin
        res_q  <= alu_res;
        opnd_q <= mem_rdata;
      end
    end
  end

  assign mem_addr  = addr_q;
  assign mem_rd    = rd_en;
  assign mem_wr    = wr_en;
  assign mem_wdata = res_q;

  assert_done_single_R1: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);
  assert_read_single_R2: assert property (@(posedge clk) disable iff (!rst_n)
    mem_rd |=> !mem_rd);
  assert_write_follows_read_R2: assert property (@(posedge clk) disable iff (!rst_n)
    mem_wr |-> $past(mem_rd, 2));
  assert_test_no_write_R3: assert property (@(posedge clk) disable iff (!rst_n)
    mem_wr |-> !op_is_test(op_q));
  assert_bitop_one_bit_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_wr && op_is_bit(op_q)) |-> ($countones(mem_wdata ^ opnd_q) <= 1));
  assert_bitop_flags_R9: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(cap_en) && op_is_bit(op_q)) |-> $stable({flag_n, flag_z, flag_c}));
  assert_carry_hold_R7: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(cap_en) && (op_q == OP_INC || op_q == OP_DEC || op_is_test(op_q)))
      |-> $stable(flag_c));
endmodule

// File: tb/tb_rmw_unit.sv
module tb_rmw_unit;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic start = 1'b0;
  logic [3:0] op = '0;
  logic [2:0] bit_idx = '0;
  logic [7:0] addr = '0;
  logic done, mem_rd, mem_wr, flag_n, flag_z, flag_c;
  logic [7:0] mem_addr, mem_wdata;
  logic [7:0] mem_rdata;

  always #2 clk = ~clk;

  rmw_unit #(.ADDR_W(8)) dut (
    .clk(clk), .rst_n(rst_n), .start(start), .op(op), .bit_idx(bit_idx),
    .addr(addr), .done(done), .mem_addr(mem_addr), .mem_rd(mem_rd),
    .mem_wr(mem_wr), .mem_wdata(mem_wdata), .mem_rdata(mem_rdata),
    .flag_n(flag_n), .flag_z(flag_z), .flag_c(flag_c)
  );

  // memory model with a preload port for the bench
  logic [7:0] mem [0:255];
  logic       pre_en = 1'b0;
  logic [7:0] pre_addr = '0, pre_data = '0;
  always @(posedge clk) begin
    if (!rst_n) begin
      for (int i = 0; i < 256; i++) mem[i] <= 8'h00;
      mem_rdata <= 8'h00;
    end else begin
      if (mem_rd) mem_rdata <= mem[mem_addr];
      if (mem_wr) mem[mem_addr] <= mem_wdata;
      if (pre_en) mem[pre_addr] <= pre_data;
    end
  end

  int checks = 0;
  int errors = 0;

  typedef struct {
    int addr; int val; int n; int z; int c; int writes; int lat; string req;
  } exp_t;
  exp_t q[$];

  int mn = 0, mz = 0, mc = 0;  // bench flag model

  task automatic check(input string req, input int act, input int exp, input string what);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  task automatic preload(input int a, input int d);
    @(negedge clk);
    pre_en = 1'b1; pre_addr = a[7:0]; pre_data = d[7:0];
    @(negedge clk);
    pre_en = 1'b0;
  endtask

  task automatic model(input int o, input int v, input int idx, input string req);
    exp_t e;
    int r, c;
    c = mc;
    case (o)
      0, 8: begin r = (v * 2) % 256; c = v / 128; end
      1:    begin r = (v / 2) + (v & 128); c = v % 2; end
      2:    r = v & (255 - (1 << idx));
      3:    r = v | (1 << idx);
      4:    begin r = 0; c = 0; end
      5:    begin r = 255 - v; c = 1; end
      6:    r = (v + 255) % 256;
      7:    r = (v + 1) % 256;
      9:    begin r = v / 2; c = v % 2; end
      10:   begin r = (256 - v) % 256; c = (r != 0) ? 1 : 0; end
      11:   begin r = (v * 2) % 256 + mc; c = v / 128; end
      12:   begin r = v / 2 + mc * 128; c = v % 2; end
      default: r = v;
    endcase
    if (o != 2 && o != 3) begin
      mn = (r >= 128) ? 1 : 0;
      mz = (r == 0) ? 1 : 0;
      mc = c;
    end
    e.addr = 0; e.val = r; e.n = mn; e.z = mz; e.c = mc;
    e.writes = (o >= 13) ? 0 : 1;
    e.lat = (o >= 13) ? 2 : 3;
    e.req = req;
    q.push_back(e);
  endtask

  // driver: pushes the expectation, then runs the operation
  task automatic run_op(input int o, input int a, input int v, input int idx, input string req);
    preload(a, v);
    model(o, v, idx, req);
    q[q.size() - 1].addr = a;
    @(negedge clk);
    start = 1'b1; op = o[3:0]; addr = a[7:0]; bit_idx = idx[2:0];
    @(negedge clk);
    start = 1'b0;
    while (!done) @(negedge clk);
    @(negedge clk);
  endtask

  // monitor: pops and compares on every done
  int wr_cnt = 0;
  int lat = 0;
  logic prev_done = 1'b0;
  always @(negedge clk) begin
    if (rst_n) begin
      if (mem_wr) wr_cnt++;
      if (mem_rd) lat = 1;
      else if (lat > 0 && !done) lat++;
      if (prev_done && done) check("R1", 1, 0, "done longer than one cycle");
      if (done) begin
        if (q.size() == 0) begin
          check("R11", 1, 0, "unexpected done");
        end else begin
          exp_t e;
          e = q.pop_front();
          check(e.req, mem[e.addr], e.val, "result");
          check("R10", {flag_n, flag_z}, {e.n[0], e.z[0]}, "N,Z");
          check(e.req, flag_c, e.c, "carry");
          check("R2", wr_cnt, e.writes, "write count");
          check("R1", lat, e.lat, "read-to-done latency");
        end
        wr_cnt = 0;
        lat = 0;
      end
      prev_done = done;
    end
  end

  initial begin
    int wd;
    wd = 0;
    while (wd < 100000) begin
      @(posedge clk);
      wd++;
    end
    check("WATCHDOG", 1, 0, "run hung");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    int keep;
    repeat (3) @(negedge clk);
    check("R12", {done, mem_rd, mem_wr}, 0, "strobes in reset");
    rst_n = 1'b1;
    @(negedge clk);
    check("R12", {flag_n, flag_z, flag_c}, 0, "flags after reset");

    run_op(13, 8'h10, 8'h80, 0, "R3");   // N=1, no write
    run_op(13, 8'h11, 8'h00, 0, "R3");   // Z=1
    run_op(14, 8'h12, 8'h05, 0, "R3");   // code 14 acts as test
    run_op(0,  8'h20, 8'h81, 0, "R4");   // 0x02, C=1
    run_op(8,  8'h21, 8'h40, 0, "R4");   // 0x80, C=0
    run_op(1,  8'h22, 8'h81, 0, "R4");   // 0xC0, C=1
    run_op(9,  8'h23, 8'h81, 0, "R4");   // 0x40, C=1
    run_op(11, 8'h24, 8'h80, 0, "R5");   // C in=1 -> 0x01, C=1
    run_op(12, 8'h25, 8'h02, 0, "R5");   // C in=1 -> 0x81, C=0
    run_op(12, 8'h26, 8'h01, 0, "R5");   // C in=0 -> 0x00, C=1
    run_op(5,  8'h27, 8'h55, 0, "R6");   // 0xAA, C=1
    run_op(10, 8'h28, 8'h01, 0, "R6");   // 0xFF, C=1
    run_op(10, 8'h29, 8'h00, 0, "R6");   // 0x00, C=0
    run_op(7,  8'h2A, 8'hFF, 0, "R7");   // 0x00, C held
    run_op(6,  8'h2B, 8'h00, 0, "R7");   // 0xFF, C held
    run_op(4,  8'h2C, 8'h7E, 0, "R8");
    run_op(3,  8'h2D, 8'h00, 7, "R9");   // 0x80, flags held
    run_op(2,  8'h2E, 8'hFF, 0, "R9");   // 0xFE, flags held
    run_op(3,  8'h2F, 8'h10, 4, "R9");   // bit already set

    // R11: second start during a running increment
    preload(8'h41, 8'h5A);
    preload(8'h40, 8'h33);
    model(7, 8'h33, 0, "R11");
    q[q.size() - 1].addr = 8'h40;
    @(negedge clk);
    start = 1'b1; op = 4'd7; addr = 8'h40;
    @(negedge clk);
    start = 1'b0;
    @(negedge clk);
    start = 1'b1; op = 4'd4; addr = 8'h41;  // modify cycle of the increment
    @(negedge clk);
    start = 1'b0;
    while (!done) @(negedge clk);
    repeat (8) @(negedge clk);
    keep = mem[8'h41];
    check("R11", keep, 8'h5A, "untouched address");
    check("R11", q.size(), 0, "pending expectations");

    // mixed sweep across all operations, with carry chaining
    for (int k = 0; k < 42; k++) begin
      run_op(k % 14, 8'h60 + k, (k * 37 + 5) % 256, k % 8, "R10");
    end

    repeat (4) @(negedge clk);
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule